// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets a clocked host read and write an external asynchronous static RAM of 128K sixteen-bit words. The host raises a one-cycle request that carries a word address, an operation flag, write data and two byte-enable bits. The controller then runs the memory's active-low select, output-enable, write-enable and per-byte strobes, and steers a shared tri-state data bus. When the access ends it returns a one-cycle ready pulse, together with read data for reads.

The memory has no clock, so each access is held for a whole number of clock cycles. That number is computed when the design is elaborated, from the clock period and the timing limits of the speed grade, all given as parameters in picoseconds. Writes are timed by the write-enable pulse, and output enable stays high for the whole write so that the memory never drives the bus against the controller. When no access is running, the memory is deselected.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During reset and whenever no access is in progress, select, output enable, write enable and both byte strobes are high, ready is low and the controller does not drive the data bus. In the cycle where ready is high, select is already high again.
- R2: A read is accepted at the first rising edge where request is high in idle with the write flag low. Ready is high for exactly one cycle, starting RD_CYC rising edges after acceptance, where RD_CYC = max(1, ceil(max(read cycle, address access, output-enable access, byte access) / clock period)). This gives 3 for a 20 ns clock and a 55/55/30/55 ns grade.
- R3: Read data is sampled from the bus at the edge that ends the access. Byte lane L is bits 8L+7..8L and is enabled by byte-enable bit L. Lane 0 uses the lower strobe and lane 1 the upper strobe. A lane that is not enabled has its strobe held high and returns zero to the host.
- R4: A write is one setup cycle with select and the enabled strobes low and write enable high. Write enable is then low for WR_CYC cycles while select stays low, followed by one hold cycle with write enable high. Ready comes WR_CYC+2 edges after acceptance. WR_CYC = max(1, ceil(pulse width / period), ceil(data setup / period), ceil(write cycle / period) - 2), which is 3 by default. The low write-enable pulse is therefore at least the pulse-width limit.
- R5: Output enable stays high throughout a write. Write data drives the bus from the edge where write enable falls until one cycle after write enable rises, and stays stable for at least the data-setup time before write enable rises.
- R6: A write changes only the byte lanes whose enable bit is set. The other byte of that word keeps its earlier value.
- R7: A request that arrives while an access is in progress is ignored. It produces no ready pulse and no memory change.
- R8: The controller never drives the data bus in a cycle where output enable is low, so the controller and the memory never drive the bus at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_req | input | 1 | Access request, sampled only in idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte enables, bit 0 = low byte |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid with ready |
| mem_addr | output | 17 | Memory address lines |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_lb_n | output | 1 | Low byte strobe, active low |
| mem_ub_n | output | 1 | High byte strobe, active low |
| mem_dq | inout | 16 | Shared data bus |

## Verification
For a read, ready and the read data are due RD_CYC rising edges after the edge that accepts the request. For a write, they are due WR_CYC+2 edges after it. When the bench issues an access, it records the cycle number at which the result is due. The scoreboard then checks, at the falling edge of each ready pulse, that the cycle count matches and that the data agrees with a shadow memory. The memory model returns garbage until the address-access and output-enable times have passed since the last change of select, address or strobes, so a read window that is too short shows up as wrong data. The model also times every write-enable pulse and the data setup in nanoseconds, and it flags any read where the bus value does not match what the model drives.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
// Shared types and elaboration-time helpers for the SRAM byte-lane controller.
// Assumes all timing limits are given in picoseconds as unsigned integers.
package sram_lane_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_READ,
        SEQ_WSETUP,
        SEQ_WPULSE,
        SEQ_WHOLD
    } seq_state_t;

    // Control strobes that depend only on the sequencer state.
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } ctl_t;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Cycles the select/output-enable window of a read must last.
    function automatic int unsigned read_cycles(input int unsigned clk_ps,
                                                input int unsigned trc, input int unsigned taa,
                                                input int unsigned toe, input int unsigned tba);
        int unsigned worst;
        worst = umax(umax(trc, taa), umax(toe, tba));
        return umax(1, ceil_div(worst, clk_ps));
    endfunction

    // Cycles write enable must stay low; setup and hold cycles add two more.
    function automatic int unsigned write_cycles(input int unsigned clk_ps,
                                                 input int unsigned twc, input int unsigned twp,
                                                 input int unsigned tds);
        int unsigned pulse;
        int unsigned whole;
        pulse = umax(ceil_div(twp, clk_ps), ceil_div(tds, clk_ps));
        whole = ceil_div(twc, clk_ps);
        if (whole > 2) pulse = umax(pulse, whole - 2);
        return umax(1, pulse);
    endfunction

    // Strobe levels presented to the memory while in a given state.
    function automatic ctl_t decode_ctl(input seq_state_t s);
        ctl_t c;
        c = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        case (s)
            SEQ_READ:   begin c.ce_n = 1'b0; c.oe_n = 1'b0; end
            SEQ_WSETUP: begin c.ce_n = 1'b0; end
            SEQ_WPULSE: begin c.ce_n = 1'b0; c.we_n = 1'b0; c.drive = 1'b1; end
            SEQ_WHOLD:  begin c.ce_n = 1'b0; c.drive = 1'b1; end
            default:    c = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
`timescale 1ns/1ps
// Down-counter that times the wait window of one access phase.
// Assumes load_val >= 1; expire is high in the last cycle of the window,
// i.e. load_val cycles after the loading edge.
module sram_wait_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    // Load a new window or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == CNT_W'(1));
endmodule

// File: rtl/sram_lane_datapath.sv
`timescale 1ns/1ps
// Tri-state data bus driver and per-lane read capture.
// Assumes drive_en is only asserted while the memory outputs are disabled.
module sram_lane_datapath #(
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drive_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              capture,
    input  logic [LANES-1:0]  lane_en,
    inout  wire  [DATA_W-1:0] dq,
    output logic [DATA_W-1:0] rdata
);
    // Drive write data onto the shared bus only when enabled.
    assign dq = drive_en ? wdata : {DATA_W{1'bz}};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Capture one byte lane at the end of a read; disabled lanes return zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata[8*l +: 8] <= 8'h00;
            end else if (capture) begin
                rdata[8*l +: 8] <= lane_en[l] ? dq[8*l +: 8] : 8'h00;
            end
        end
    end
endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
// Access sequencer: accepts host requests in idle and steps through the read
// or write phases, registering every memory strobe so none can glitch.
// Assumes RD_CYC and WR_CYC fit in CNT_W bits and are at least one.
module sram_seq_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8,
    parameter int CNT_W  = 3,
    parameter int RD_CYC = 3,
    parameter int WR_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [LANES-1:0]  host_be,
    input  logic              expire,
    output logic              timer_load,
    output logic [CNT_W-1:0]  timer_val,
    output logic              capture,
    output logic              ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [LANES-1:0]  lane_n,
    output logic              drv_en,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANES-1:0]  be_q
);
    seq_state_t       state, state_n;
    logic             accept;
    logic [LANES-1:0] be_next;
    ctl_t             ctl_n;

    assign accept  = (state == SEQ_IDLE) && host_req;
    assign be_next = accept ? host_be : be_q;
    assign ctl_n   = decode_ctl(state_n);
    assign capture = (state == SEQ_READ) && expire;

    // Next-state selection for the access phases.
    always_comb begin
        state_n = state;
        case (state)
            SEQ_IDLE:   if (accept) state_n = host_we ? SEQ_WSETUP : SEQ_READ;
            SEQ_READ:   if (expire) state_n = SEQ_IDLE;
            SEQ_WSETUP: state_n = SEQ_WPULSE;
            SEQ_WPULSE: if (expire) state_n = SEQ_WHOLD;
            SEQ_WHOLD:  state_n = SEQ_IDLE;
            default:    state_n = SEQ_IDLE;
        endcase
    end

    // Start the read window on acceptance and the write pulse after setup.
    always_comb begin
        timer_load = (accept && !host_we) || (state == SEQ_WSETUP);
        timer_val  = (state == SEQ_WSETUP) ? CNT_W'(WR_CYC) : CNT_W'(RD_CYC);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_n;
    end

    // Latch the request fields when the request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            wdata_q  <= '0;
            be_q     <= '0;
        end else if (accept) begin
            mem_addr <= host_addr;
            wdata_q  <= host_wdata;
            be_q     <= host_be;
        end
    end

    // Registered memory strobes and bus driver enable, decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n   <= 1'b1;
            oe_n   <= 1'b1;
            we_n   <= 1'b1;
            drv_en <= 1'b0;
            lane_n <= '1;
        end else begin
            ce_n   <= ctl_n.ce_n;
            oe_n   <= ctl_n.oe_n;
            we_n   <= ctl_n.we_n;
            drv_en <= ctl_n.drive;
            lane_n <= (state_n == SEQ_IDLE) ? '1 : ~be_next;
        end
    end

    // One-cycle completion pulse at the end of a read window or write hold.
    always_ff @(posedge clk) begin
        if (!rst_n) ready <= 1'b0;
        else        ready <= capture || (state == SEQ_WHOLD);
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
// Top level of the SRAM byte-lane controller. It derives the wait-state counts
// from the timing parameters (picoseconds) and connects the sequencer, the
// wait timer and the bus datapath. Assumes a 16-bit memory with two byte strobes.
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int CLK_PS = 20000,
    parameter int T_RC_PS = 55000,
    parameter int T_AA_PS = 55000,
    parameter int T_OE_PS = 30000,
    parameter int T_BA_PS = 55000,
    parameter int T_WC_PS = 55000,
    parameter int T_WP_PS = 45000,
    parameter int T_DS_PS = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [1:0]        host_be,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    inout  wire  [DATA_W-1:0] mem_dq
);
    localparam int LANES  = DATA_W / 8;
    localparam int RD_CYC = int'(read_cycles(CLK_PS, T_RC_PS, T_AA_PS, T_OE_PS, T_BA_PS));
    localparam int WR_CYC = int'(write_cycles(CLK_PS, T_WC_PS, T_WP_PS, T_DS_PS));
    localparam int MAX_CYC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int CNT_W  = $clog2(MAX_CYC + 1);

    logic              timer_load;
    logic [CNT_W-1:0]  timer_val;
    logic              expire;
    logic              capture;
    logic              drv_en;
    logic [LANES-1:0]  lane_n;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;

    sram_seq_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES),
        .CNT_W(CNT_W), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_be(host_be),
        .expire(expire), .timer_load(timer_load), .timer_val(timer_val),
        .capture(capture), .ready(host_ready), .mem_addr(mem_addr),
        .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .lane_n(lane_n),
        .drv_en(drv_en), .wdata_q(wdata_q), .be_q(be_q)
    );

    sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(timer_load),
        .load_val(timer_val), .expire(expire)
    );

    sram_lane_datapath #(.DATA_W(DATA_W), .LANES(LANES)) u_dp (
        .clk(clk), .rst_n(rst_n), .drive_en(drv_en), .wdata(wdata_q),
        .capture(capture), .lane_en(be_q), .dq(mem_dq), .rdata(host_rdata)
    );

    assign mem_lb_n = lane_n[0];
    assign mem_ub_n = lane_n[1];
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for the SRAM byte-lane controller, attached by bind.
// Assumes it observes the registered memory strobes and the bus driver enable.
module sram_lane_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic oe_n,
    input logic we_n,
    input logic drv_en,
    input logic ready
);
    // R1: the memory is deselected in the completion cycle.
    p_ready_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ce_n);

    // R2: ready is a single-cycle pulse.
    p_ready_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R4: write enable is only low while the memory is selected.
    p_we_selected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !ce_n);

    // R5: output enable stays high while write enable is low.
    p_oe_off_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> oe_n);

    // R5: data is still driven in the cycle after write enable rises.
    p_drive_after_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> drv_en);

    // R8: no bus drive while the memory outputs may be on.
    p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> oe_n);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(mem_ce_n), .oe_n(mem_oe_n),
    .we_n(mem_we_n), .drv_en(drv_en), .ready(host_ready)
);

// File: tb/sram_lane_ctrl_test.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver pushes expected completions, a monitor checks them.
module sram_lane_ctrl_test;
    localparam int CLK_NS = 20;
    localparam int RD_LAT = (55 + CLK_NS - 1) / CLK_NS;                       // R2: 3
    localparam int WR_P1  = (45 + CLK_NS - 1) / CLK_NS;
    localparam int WR_P2  = (25 + CLK_NS - 1) / CLK_NS;
    localparam int WR_P3  = (55 + CLK_NS - 1) / CLK_NS - 2;
    localparam int WR_LAT = (WR_P1 > WR_P2 ? (WR_P1 > WR_P3 ? WR_P1 : WR_P3)
                                           : (WR_P2 > WR_P3 ? WR_P2 : WR_P3)); // R4: 3

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [16:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_be = '0;
    logic        host_ready;
    logic [15:0] host_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
    wire  [15:0] mem_dq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sram_lane_ctrl uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
        .host_ready(host_ready), .host_rdata(host_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq(mem_dq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0] m_lo [int];
    logic [7:0] m_hi [int];
    logic [7:0] sh_lo [int];
    logic [7:0] sh_hi [int];
    logic [15:0] m_dout = 16'h0000;
    logic [1:0]  m_drv = 2'b00;
    realtime t_sel = 0.0, t_oe = 0.0, t_wef = 0.0, t_dq = 0.0;
    bit contention = 1'b0;

    function automatic logic [7:0] lane_rd(input bit hi, input int a);
        if (hi) return m_hi.exists(a) ? m_hi[a] : 8'h00;
        return m_lo.exists(a) ? m_lo[a] : 8'h00;
    endfunction

    function automatic logic [15:0] shadow(input int a);
        logic [15:0] v;
        v[7:0]  = sh_lo.exists(a) ? sh_lo[a] : 8'h00;
        v[15:8] = sh_hi.exists(a) ? sh_hi[a] : 8'h00;
        return v;
    endfunction

    assign mem_dq[7:0]  = m_drv[0] ? m_dout[7:0]  : 8'hzz;
    assign mem_dq[15:8] = m_drv[1] ? m_dout[15:8] : 8'hzz;

    always @(mem_addr or mem_ce_n or mem_lb_n or mem_ub_n) t_sel = $realtime;
    always @(mem_oe_n) t_oe = $realtime;
    always @(mem_dq) t_dq = $realtime;

    // Model output: garbage until the access times have passed; R8 bus compare.
    always #1 begin
        if (m_drv[0] && mem_dq[7:0] !== m_dout[7:0]) contention = 1'b1;
        if (m_drv[1] && mem_dq[15:8] !== m_dout[15:8]) contention = 1'b1;
        m_drv[0] = !mem_ce_n && !mem_oe_n && mem_we_n && !mem_lb_n;
        m_drv[1] = !mem_ce_n && !mem_oe_n && mem_we_n && !mem_ub_n;
        if (($realtime - t_sel >= 55.0) && ($realtime - t_oe >= 30.0))
            m_dout = {lane_rd(1'b1, int'(mem_addr)), lane_rd(1'b0, int'(mem_addr))};
        else
            m_dout = 16'hDEAD;
    end

    // R4: write enable must fall while selected.
    always @(negedge mem_we_n) begin
        t_wef = $realtime;
        if (rst_n) check(!mem_ce_n, "R4 select low at WE fall", {31'd0, mem_ce_n}, 32'd0);
    end

    // R4/R5: write ends at WE rise; check pulse width and data setup, then commit.
    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce_n) begin
            check(($realtime - t_wef) >= 45.0, "R4 WE pulse width ns",
                  int'($realtime - t_wef), 32'd45);
            check(($realtime - t_dq) >= 25.0, "R5 data setup ns",
                  int'($realtime - t_dq), 32'd25);
            check(mem_oe_n, "R5 OE high at write end", {31'd0, mem_oe_n}, 32'd1);
            if (!mem_lb_n) m_lo[int'(mem_addr)] = mem_dq[7:0];
            if (!mem_ub_n) m_hi[int'(mem_addr)] = mem_dq[15:8];
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit          rd;
        logic [15:0] exp;
        int          due;
    } item_t;
    item_t sbq[$];

    // Monitor: compare every completion against the queue head.
    always @(negedge clk) begin
        if (rst_n && host_ready && !done) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R7 unexpected ready", 32'd1, 32'd0);
            end else begin
                item_t it;
                it = sbq.pop_front();
                check(cyc == it.due, it.rd ? "R2 read latency" : "R4 write latency",
                      cyc, it.due);
                check(mem_ce_n, "R1 deselected at ready", {31'd0, mem_ce_n}, 32'd1);
                if (it.rd) check(host_rdata == it.exp, "R3 read data (R6 lanes)",
                                 {16'd0, host_rdata}, {16'd0, it.exp});
            end
        end
    end

    // Driver: issue one access and wait for its completion.
    task automatic access(input bit rd, input logic [16:0] a, input logic [15:0] d,
                          input logic [1:0] be, input bit stray);
        item_t it;
        @(negedge clk);
        it.rd  = rd;
        it.due = cyc + 1 + (rd ? RD_LAT : WR_LAT + 2);
        it.exp = 16'h0000;
        if (rd) begin
            logic [15:0] s;
            s = shadow(int'(a));
            it.exp = {be[1] ? s[15:8] : 8'h00, be[0] ? s[7:0] : 8'h00};
        end else begin
            if (be[0]) sh_lo[int'(a)] = d[7:0];
            if (be[1]) sh_hi[int'(a)] = d[15:8];
        end
        sbq.push_back(it);
        host_req = 1'b1; host_we = !rd; host_addr = a; host_wdata = d; host_be = be;
        @(negedge clk);
        host_req = 1'b0;
        if (stray) begin
            // R7: a write request while busy must be ignored.
            @(negedge clk);
            host_req = 1'b1; host_we = 1'b1; host_wdata = 16'hFFFF; host_be = 2'b11;
            @(negedge clk);
            host_req = 1'b0;
        end
        while (sbq.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog", cyc, 32'd0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of the memory interface.
        check(mem_ce_n, "R1 reset ce", {31'd0, mem_ce_n}, 32'd1);
        check(mem_oe_n, "R1 reset oe", {31'd0, mem_oe_n}, 32'd1);
        check(mem_we_n, "R1 reset we", {31'd0, mem_we_n}, 32'd1);
        check(mem_lb_n && mem_ub_n, "R1 reset strobes", {30'd0, mem_ub_n, mem_lb_n}, 32'd3);
        check(!host_ready, "R1 reset ready", {31'd0, host_ready}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(mem_ce_n && mem_oe_n && mem_we_n, "R1 idle strobes",
              {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, 32'd7);

        access(1'b0, 17'h00010, 16'h1234, 2'b11, 1'b0);
        access(1'b1, 17'h00010, 16'h0000, 2'b11, 1'b0);
        access(1'b0, 17'h1FFFF, 16'hABCD, 2'b01, 1'b0);   // R6 low lane only
        access(1'b1, 17'h1FFFF, 16'h0000, 2'b11, 1'b0);
        access(1'b0, 17'h1FFFF, 16'h5500, 2'b10, 1'b0);   // R6 high lane only
        access(1'b1, 17'h1FFFF, 16'h0000, 2'b11, 1'b0);
        access(1'b1, 17'h00010, 16'h0000, 2'b01, 1'b0);   // R3 lane masking
        access(1'b1, 17'h00010, 16'h0000, 2'b10, 1'b0);
        access(1'b1, 17'h00010, 16'h0000, 2'b00, 1'b0);
        access(1'b1, 17'h00010, 16'h0000, 2'b11, 1'b1);   // R7 stray request
        access(1'b1, 17'h00010, 16'h0000, 2'b11, 1'b0);
        for (int i = 0; i < 6; i++) begin
            access(1'b0, 17'(i * 17'h1111), 16'(16'h0F1E * (i + 1)), 2'b11, 1'b0);
        end
        for (int i = 0; i < 6; i++) begin
            access(1'b1, 17'(i * 17'h1111), 16'h0000, 2'b11, 1'b0);
        end
        check(!contention, "R8 bus contention", {31'd0, contention}, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule